// File: doc/BRIEF.md
# Asynchronous Serial Frame Controller

This block moves characters over a pair of asynchronous serial lines. A host places one character in a single-entry transmit holding buffer. The block frames it with a start bit, the data bits, an optional parity bit and one or two stop bits, and shifts it out least significant bit first. On the receive side, the block finds start bits on the incoming line and samples each bit at its middle. It places the finished character in a single-entry receive buffer and raises a ready flag until the host takes the character.

Every timing step is driven by an external pulse that arrives sixteen times per bit period; producing that pulse is the job of a separate baud generator. The line format comes from static configuration inputs: format select, stop-bit count, parity sense, parity checking, and enables for frame-error and overrun detection. Three error flags stay set once raised. The host clears each one with its own strobe. The receiver starts switched off and is turned on by a one-shot strobe.

Top module: `sfc_top`

## Requirements
- R1: After reset the transmit line is high, `tx_empty` is 1, `rx_ready` is 0, all three error flags are 0 and the receiver is off.
- R2: The transmit frame is sent least significant bit first. It is a low start bit, then the data bits, then a parity bit (when the format has one), then stop bits that are high, and each bit lasts 16 ticks. The line stays high between frames. `fmt_sel` encodings: 0 = 8 data bits with no parity, 1 = 8 data bits plus parity, 2 = 7 data bits plus parity, 3 = same as 0. `stop2_sel`=1 sends two stop bits. `par_odd_sel`=1 makes the count of ones in the data and parity bits odd, and 0 makes it even.
- R3: A write to the transmit buffer clears `tx_empty`. `tx_empty` returns to 1 once the shifter takes the character. A write made while a character is still pending is dropped, and it sets `oe_flag` when `oe_chk_en`=1.
- R4: Characters on `rxd_i` are ignored until `rx_on_set` has been pulsed.
- R5: The receiver checks a falling edge again 8 ticks later. If the line is high again at that point, the receiver discards the event with no character and no error.
- R6: After the last frame bit, `rx_ready` rises and `rx_char` holds the data bits. In format 2, bit 7 of `rx_char` is 0. A one-cycle `rx_take` clears `rx_ready`.
- R7: With `par_chk_en`=1 and a format that carries parity, a parity bit that does not match the sense selected by `par_odd_sel` sets `pe_flag`. With `par_chk_en`=0, no parity error is ever flagged.
- R8: A low first stop bit sets `fe_flag`. With `stop2_sel`=1, a low second stop bit also sets `fe_flag`. With `fe_chk_en`=0, `fe_flag` never sets.
- R9: If a character completes while `rx_ready` is still 1, `oe_flag` sets and the older character stays in `rx_char`.
- R10: Each error flag stays set until its own clear strobe. Clearing one flag leaves the others unchanged.
- R11: With `oe_chk_en`=0, neither kind of overrun sets `oe_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling pulse, 16 per bit period |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| fmt_sel | input | 2 | Line format select |
| stop2_sel | input | 1 | Two stop bits when 1 |
| par_chk_en | input | 1 | Receive parity checking enable |
| par_odd_sel | input | 1 | Odd parity when 1, even when 0 |
| fe_chk_en | input | 1 | Frame-error detection enable |
| oe_chk_en | input | 1 | Overrun detection enable |
| rx_on_set | input | 1 | Strobe that switches the receiver on |
| fe_clr | input | 1 | Strobe that clears the frame-error flag |
| pe_clr | input | 1 | Strobe that clears the parity-error flag |
| oe_clr | input | 1 | Strobe that clears the overrun flag |
| tx_load | input | 1 | Write strobe for the transmit buffer |
| tx_char | input | 8 | Character to transmit |
| rx_take | input | 1 | Strobe that takes the received character |
| rx_char | output | 8 | Received character |
| rx_ready | output | 1 | Received character available |
| tx_empty | output | 1 | Transmit buffer free |
| fe_flag | output | 1 | Sticky frame-error flag |
| pe_flag | output | 1 | Sticky parity-error flag |
| oe_flag | output | 1 | Sticky overrun flag |

## Verification
A write clears `tx_empty` in the following cycle. The shifter takes the character one cycle after that when it is idle, and the start bit appears within a cycle of that capture. The bench therefore samples `tx_empty` on the first falling clock edge after the write and samples the line at bit middles, measured from the observed falling edge. A received character is complete two synchronizer cycles plus at most one tick after the middle of its last stop bit. `rx_ready`, `rx_char` and the error flags follow one cycle later, so the bench reads them only after driving the whole last stop bit, which leaves about half a bit period of margin. Error flags and clears take effect one cycle after their cause, and the bench checks them on the next falling clock edge.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int FRAME_W = 12;

  localparam logic [1:0] FMT_8N = 2'd0;
  localparam logic [1:0] FMT_8P = 2'd1;
  localparam logic [1:0] FMT_7P = 2'd2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;

  function automatic logic [3:0] fmt_data_len(input logic [1:0] fmt);
    return (fmt == FMT_7P) ? 4'd7 : 4'd8;
  endfunction

  function automatic logic fmt_has_par(input logic [1:0] fmt);
    return (fmt == FMT_8P) || (fmt == FMT_7P);
  endfunction

  function automatic logic [7:0] fmt_mask(input logic [1:0] fmt, input logic [7:0] d);
    return (fmt == FMT_7P) ? {1'b0, d[6:0]} : d;
  endfunction

  // bits that follow the start bit: data, parity, stop(s)
  function automatic logic [3:0] fmt_tail_len(input logic [1:0] fmt, input logic two_stop);
    return fmt_data_len(fmt) + {3'd0, fmt_has_par(fmt)} + 4'd1 + {3'd0, two_stop};
  endfunction

  function automatic logic [FRAME_W-1:0] fmt_build(input logic [1:0] fmt, input logic odd,
                                                   input logic [7:0] d);
    logic [FRAME_W-1:0] f;
    logic [3:0]         nd;
    f    = '1;
    f[0] = 1'b0;
    nd   = fmt_data_len(fmt);
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < nd) f[i+1] = d[i];
    end
    if (fmt_has_par(fmt)) f[nd + 4'd1] = (^fmt_mask(fmt, d)) ^ odd;
    return f;
  endfunction

endpackage

// File: rtl/sfc_tx.sv
module sfc_tx import sfc_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic [1:0] fmt,
  input  logic       par_odd,
  input  logic       two_stop,
  output logic       txd,
  output logic       buf_empty,
  output logic       ovr_pulse
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

  logic                 full_q, full_d;
  logic [7:0]           hold_q, hold_d;
  logic                 busy_q, busy_d;
  logic [FRAME_W-1:0]   sh_q, sh_d;
  logic [3:0]           left_q, left_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic                 take;

  assign take      = full_q && !busy_q;
  assign ovr_pulse = wr && full_q && !take;
  assign buf_empty = !full_q;
  assign txd       = busy_q ? sh_q[0] : 1'b1;

  always_comb begin
    full_d = full_q;
    hold_d = hold_q;
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    if (take) full_d = 1'b0;
    if (wr && !ovr_pulse) begin
      full_d = 1'b1;
      hold_d = wdata;
    end
    if (take) begin
      busy_d = 1'b1;
      sh_d   = fmt_build(fmt, par_odd, hold_q);
      left_d = fmt_tail_len(fmt, two_stop);
      cnt_d  = '0;
    end else if (busy_q && tick) begin
      if (cnt_q == LAST_TICK) begin
        cnt_d = '0;
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        if (left_q == 4'd0) busy_d = 1'b0;
        else                left_d = left_q - 4'd1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      full_q <= full_d;
      hold_q <= hold_d;
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
    end
  end

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);
  a_r3_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr && full_q && busy_q |=> hold_q == $past(hold_q));

endmodule

// File: rtl/sfc_rx.sv
module sfc_rx import sfc_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       en,
  input  logic [1:0] fmt,
  input  logic       two_stop,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       done,
  output logic [7:0] data,
  output logic       pe,
  output logic       fe
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_TICK  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

  logic               rs1_q, rs2_q;
  rx_state_e          st_q, st_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [3:0]         idx_q, idx_d;
  logic [FRAME_W-2:0] bits_q, bits_d;
  logic               fin;
  logic [3:0]         last_idx, nd, stop_idx;
  logic               has_par;
  logic [7:0]         dat_w;
  logic               pe_w, fe_w;

  assign last_idx = fmt_tail_len(fmt, two_stop) - 4'd1;
  assign nd       = fmt_data_len(fmt);
  assign has_par  = fmt_has_par(fmt);
  assign stop_idx = nd + {3'd0, has_par};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    bits_d = bits_q;
    fin    = 1'b0;
    if (en && tick) begin
      unique case (st_q)
        RX_IDLE: if (!rs2_q) begin
          st_d  = RX_START;
          cnt_d = '0;
        end
        RX_START: if (cnt_q == MID_TICK) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = rs2_q ? RX_IDLE : RX_BITS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        RX_BITS: if (cnt_q == LAST_TICK) begin
          cnt_d         = '0;
          bits_d[idx_q] = rs2_q;
          if (idx_q == last_idx) begin
            fin  = 1'b1;
            st_d = RX_IDLE;
          end else begin
            idx_d = idx_q + 4'd1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  assign dat_w = fmt_mask(fmt, bits_d[7:0]);
  assign pe_w  = par_en && has_par && (bits_d[nd] != ((^dat_w) ^ par_odd));
  assign fe_w  = !bits_d[stop_idx] || (two_stop && !bits_d[stop_idx + 4'd1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b1;
      rs2_q  <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      bits_q <= '1;
      done   <= 1'b0;
      pe     <= 1'b0;
      fe     <= 1'b0;
      data   <= '0;
    end else begin
      rs1_q  <= rxd;
      rs2_q  <= rs1_q;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      bits_q <= bits_d;
      done   <= fin;
      pe     <= fin && pe_w;
      fe     <= fin && fe_w;
      if (fin) data <= dat_w;
    end
  end

  a_r4_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> st_q == RX_IDLE);
  a_r6_done_after_bits: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_q) == RX_BITS);

endmodule

// File: rtl/sfc_flags.sv
module sfc_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_v,
  input  logic [NF-1:0] clr_v,
  output logic [NF-1:0] flag_q
);
  logic [NF-1:0] flag_d;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_v[i]) flag_d[i] = 1'b0;
      if (set_v[i]) flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] && !clr_v[i] |=> flag_q[i]);
  end

endmodule

// File: rtl/sfc_top.sv
module sfc_top import sfc_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd_i,
  output logic       txd_o,
  input  logic [1:0] fmt_sel,
  input  logic       stop2_sel,
  input  logic       par_chk_en,
  input  logic       par_odd_sel,
  input  logic       fe_chk_en,
  input  logic       oe_chk_en,
  input  logic       rx_on_set,
  input  logic       fe_clr,
  input  logic       pe_clr,
  input  logic       oe_clr,
  input  logic       tx_load,
  input  logic [7:0] tx_char,
  input  logic       rx_take,
  output logic [7:0] rx_char,
  output logic       rx_ready,
  output logic       tx_empty,
  output logic       fe_flag,
  output logic       pe_flag,
  output logic       oe_flag
);
  logic       rx_on_q;
  logic       rx_done, rx_pe, rx_fe;
  logic [7:0] rx_dat;
  logic       tx_ovr, rx_ovr;
  logic       rdy_d;
  logic [7:0] char_d;
  logic [2:0] set_v, clr_v, flag_v;

  sfc_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .wr(tx_load), .wdata(tx_char),
    .fmt(fmt_sel), .par_odd(par_odd_sel), .two_stop(stop2_sel),
    .txd(txd_o), .buf_empty(tx_empty), .ovr_pulse(tx_ovr)
  );

  sfc_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd_i), .en(rx_on_q),
    .fmt(fmt_sel), .two_stop(stop2_sel), .par_en(par_chk_en), .par_odd(par_odd_sel),
    .done(rx_done), .data(rx_dat), .pe(rx_pe), .fe(rx_fe)
  );

  assign rx_ovr = rx_done && rx_ready && !rx_take;

  always_comb begin
    rdy_d  = rx_ready;
    char_d = rx_char;
    if (rx_take) rdy_d = 1'b0;
    if (rx_done && !rx_ovr) begin
      rdy_d  = 1'b1;
      char_d = rx_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_on_q  <= 1'b0;
      rx_ready <= 1'b0;
      rx_char  <= '0;
    end else begin
      rx_on_q  <= rx_on_q | rx_on_set;
      rx_ready <= rdy_d;
      rx_char  <= char_d;
    end
  end

  // flag order: 0 frame, 1 parity, 2 overrun
  assign set_v = {oe_chk_en && (tx_ovr || rx_ovr), rx_pe, fe_chk_en && rx_fe};
  assign clr_v = {oe_clr, pe_clr, fe_clr};

  sfc_flags #(.NF(3)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .flag_q(flag_v)
  );

  assign fe_flag = flag_v[0];
  assign pe_flag = flag_v[1];
  assign oe_flag = flag_v[2];

  a_r9_old_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rx_take |=> $stable(rx_char));
  a_r6_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && $past(fmt_sel) == FMT_7P |-> !rx_dat[7]);
  a_r8_fe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_chk_en && !fe_flag && !rx_fe |=> !fe_flag);
  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_chk_en && !oe_flag |=> !oe_flag);
  a_r8_fe_set: assert property (@(posedge clk) disable iff (!rst_n)
    fe_chk_en && rx_fe |=> fe_flag);

endmodule

// File: tb/tb_sfc_top.sv
module tb_sfc_top;
  localparam int BITCLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic [1:0] tcnt = 2'd0;
  logic rxd_i = 1'b1;
  logic txd_o;
  logic [1:0] fmt_sel = 2'd0;
  logic stop2_sel = 1'b0, par_chk_en = 1'b0, par_odd_sel = 1'b0;
  logic fe_chk_en = 1'b1, oe_chk_en = 1'b1;
  logic rx_on_set = 1'b0, fe_clr = 1'b0, pe_clr = 1'b0, oe_clr = 1'b0;
  logic tx_load = 1'b0, rx_take = 1'b0;
  logic [7:0] tx_char = 8'd0;
  logic [7:0] rx_char;
  logic rx_ready, tx_empty, fe_flag, pe_flag, oe_flag;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  sfc_top dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_i(rxd_i), .txd_o(txd_o),
    .fmt_sel(fmt_sel), .stop2_sel(stop2_sel), .par_chk_en(par_chk_en),
    .par_odd_sel(par_odd_sel), .fe_chk_en(fe_chk_en), .oe_chk_en(oe_chk_en),
    .rx_on_set(rx_on_set), .fe_clr(fe_clr), .pe_clr(pe_clr), .oe_clr(oe_clr),
    .tx_load(tx_load), .tx_char(tx_char), .rx_take(rx_take), .rx_char(rx_char),
    .rx_ready(rx_ready), .tx_empty(tx_empty), .fe_flag(fe_flag), .pe_flag(pe_flag),
    .oe_flag(oe_flag)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt    <= tcnt + 2'd1;
    os_tick <= (tcnt == 2'd3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_data(input logic [1:0] m);
    return (m == 2'd2) ? 7 : 8;
  endfunction

  function automatic int n_par(input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) ? 1 : 0;
  endfunction

  function automatic int frame_len(input logic [1:0] m, input logic t2);
    return 2 + n_data(m) + n_par(m) + (t2 ? 1 : 0);
  endfunction

  function automatic logic [11:0] make_frame(input logic [1:0] m, input logic odd,
                                             input logic [7:0] d);
    logic [11:0] f;
    logic p;
    f = 12'hFFF;
    f[0] = 1'b0;
    p = odd;
    for (int i = 0; i < n_data(m); i++) begin
      f[1+i] = d[i];
      p = p ^ d[i];
    end
    if (n_par(m) == 1) f[1 + n_data(m)] = p;
    return f;
  endfunction

  function automatic logic [7:0] exp_char(input logic [1:0] m, input logic [7:0] d);
    return (m == 2'd2) ? (d & 8'h7F) : d;
  endfunction

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rxd_i = f[i];
      repeat (BITCLK - 1) @(negedge clk);
    end
    @(negedge clk) rxd_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk) begin tx_load = 1'b1; tx_char = d; end
    @(negedge clk) tx_load = 1'b0;
  endtask

  task automatic watch_tx(input logic [11:0] f, input int n, input string req);
    logic [11:0] got;
    int t;
    got = 12'hFFF;
    t = 0;
    while (txd_o !== 1'b0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (BITCLK / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd_o;
      if (i < n - 1) repeat (BITCLK) @(negedge clk);
    end
    check(got == f, req, int'(got), int'(f));
  endtask

  task automatic take_rx();
    @(negedge clk) rx_take = 1'b1;
    @(negedge clk) rx_take = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk) begin fe_clr = 1'b1; pe_clr = 1'b1; oe_clr = 1'b1; end
    @(negedge clk) begin fe_clr = 1'b0; pe_clr = 1'b0; oe_clr = 1'b0; end
  endtask

  initial begin
    logic [11:0] f, fa;
    logic [7:0] d, da;
    int n, bad;
    bit exp_pe;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(txd_o == 1'b1, "R1 txd idle", txd_o, 1);
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    check(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
    check({fe_flag, pe_flag, oe_flag} == 3'b000, "R1 flags", {fe_flag, pe_flag, oe_flag}, 0);

    // R4 receiver off until strobe
    send_rx(make_frame(2'd0, 1'b0, 8'hA5), frame_len(2'd0, 1'b0));
    repeat (BITCLK) @(negedge clk);
    check(rx_ready == 1'b0, "R4 receiver off ignores line", rx_ready, 0);
    @(negedge clk) rx_on_set = 1'b1;
    @(negedge clk) rx_on_set = 1'b0;

    // R5 false start
    @(negedge clk) rxd_i = 1'b0;
    repeat (16) @(negedge clk);
    rxd_i = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_ready == 1'b0, "R5 glitch gives no char", rx_ready, 0);
    check(fe_flag == 1'b0, "R5 glitch gives no error", fe_flag, 0);
    send_rx(make_frame(2'd0, 1'b0, 8'h3C), frame_len(2'd0, 1'b0));
    check(rx_ready == 1'b1 && rx_char == 8'h3C, "R5 frame after glitch", rx_char, 8'h3C);
    take_rx();
    check(rx_ready == 1'b0, "R6 take clears ready", rx_ready, 0);

    // R2 R6 R7 random frames both directions
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      fmt_sel = 2'($urandom % 4);
      par_odd_sel = 1'($urandom % 2);
      stop2_sel = 1'($urandom % 2);
      par_chk_en = 1'($urandom % 2);
      d = 8'($urandom);
      f = make_frame(fmt_sel, par_odd_sel, d);
      n = frame_len(fmt_sel, stop2_sel);
      exp_pe = 1'b0;
      if (n_par(fmt_sel) == 1 && ($urandom % 3) == 0) begin
        f[1 + n_data(fmt_sel)] = ~f[1 + n_data(fmt_sel)];
        exp_pe = par_chk_en;
      end
      send_rx(f, n);
      check(rx_ready == 1'b1, "R6 rx_ready after frame", rx_ready, 1);
      check(rx_char == exp_char(fmt_sel, d), "R6 rx data", rx_char, exp_char(fmt_sel, d));
      check(pe_flag == exp_pe, "R7 parity flag", pe_flag, exp_pe);
      check(fe_flag == 1'b0, "R8 no frame error", fe_flag, 0);
      take_rx();
      clear_all();
      tx_write(d);
      watch_tx(make_frame(fmt_sel, par_odd_sel, d), n, "R2 tx frame");
    end

    // R8 frame errors
    @(negedge clk) begin fmt_sel = 2'd1; stop2_sel = 1'b0; par_chk_en = 1'b1; par_odd_sel = 1'b0; end
    f = make_frame(2'd1, 1'b0, 8'h81);
    f[10] = 1'b0;
    send_rx(f, 11);
    check(fe_flag == 1'b1, "R8 low stop sets fe", fe_flag, 1);
    check(rx_char == 8'h81, "R8 char stored", rx_char, 8'h81);
    take_rx();
    send_rx(make_frame(2'd1, 1'b0, 8'h11), 11);
    check(fe_flag == 1'b1, "R10 fe stays set", fe_flag, 1);
    take_rx();
    @(negedge clk) pe_clr = 1'b1;
    @(negedge clk) pe_clr = 1'b0;
    check(fe_flag == 1'b1, "R10 pe clear leaves fe", fe_flag, 1);
    @(negedge clk) fe_clr = 1'b1;
    @(negedge clk) fe_clr = 1'b0;
    check(fe_flag == 1'b0, "R10 fe clear strobe", fe_flag, 0);
    @(negedge clk) stop2_sel = 1'b1;
    f = make_frame(2'd1, 1'b0, 8'h42);
    f[11] = 1'b0;
    send_rx(f, 12);
    check(fe_flag == 1'b1, "R8 second stop low", fe_flag, 1);
    take_rx();
    clear_all();
    @(negedge clk) fe_chk_en = 1'b0;
    f = make_frame(2'd1, 1'b0, 8'h24);
    f[10] = 1'b0;
    send_rx(f, 12);
    check(fe_flag == 1'b0, "R8 detection disabled", fe_flag, 0);
    take_rx();
    @(negedge clk) begin fe_chk_en = 1'b1; stop2_sel = 1'b0; fmt_sel = 2'd0; end

    // R9 receive overrun
    send_rx(make_frame(2'd0, 1'b0, 8'hC3), 10);
    send_rx(make_frame(2'd0, 1'b0, 8'h5A), 10);
    check(oe_flag == 1'b1, "R9 overrun flag", oe_flag, 1);
    check(rx_char == 8'hC3, "R9 older char kept", rx_char, 8'hC3);
    take_rx();
    clear_all();
    check(oe_flag == 1'b0, "R10 oe clear strobe", oe_flag, 0);
    @(negedge clk) oe_chk_en = 1'b0;
    send_rx(make_frame(2'd0, 1'b0, 8'h01), 10);
    send_rx(make_frame(2'd0, 1'b0, 8'h02), 10);
    check(oe_flag == 1'b0, "R11 rx overrun gated", oe_flag, 0);
    take_rx();

    // R3 transmit buffer and overrun
    tx_write(8'h96);
    tx_write(8'h69);
    check(tx_empty == 1'b0, "R3 buffer pending", tx_empty, 0);
    tx_write(8'hFF);
    check(oe_flag == 1'b0, "R11 tx overrun gated", oe_flag, 0);
    watch_tx(make_frame(2'd0, 1'b0, 8'h96), 10, "R3 first char");
    watch_tx(make_frame(2'd0, 1'b0, 8'h69), 10, "R3 second char");
    @(negedge clk) oe_chk_en = 1'b1;
    repeat (BITCLK) @(negedge clk);
    check(tx_empty == 1'b1, "R3 buffer drained", tx_empty, 1);
    bad = 0;
    repeat (1500) begin
      @(negedge clk);
      if (txd_o !== 1'b1) bad++;
    end
    check(bad == 0, "R3 dropped write never sent", bad, 0);
    da = 8'h0F;
    fa = make_frame(2'd0, 1'b0, da);
    tx_write(da);
    tx_write(8'hF0);
    tx_write(8'h55);
    check(oe_flag == 1'b1, "R3 write while pending sets oe", oe_flag, 1);
    watch_tx(fa, 10, "R3 char after overrun");
    repeat (2000) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule